// File: doc/BRIEF.md
# BCD calendar time counter

This block holds a wall-clock time and date made of seven byte-wide fields: seconds, minutes, hours (24-hour form), weekday, day of month, month and a two-digit year. Each single-cycle pulse on the tick input moves the stored time forward by exactly one second. The carry passes through every field and follows calendar month lengths, including leap-year Februaries. A data-mode input selects how the fields are interpreted and produced. In packed BCD mode the tens digit sits in the upper nibble and the units digit in the lower nibble. In binary mode each field is a plain unsigned count.

A host loads any one field per cycle through a select/data write port. A freeze input holds the whole time still while software rewrites it. Writes are still accepted during freeze. The two-digit year is read as 1950–2049: 50..99 stand for 1950..1999 and 00..49 for 2000..2049. Every year in that window whose value is a multiple of four is a leap year. The one-second tick itself comes from outside the block.

Top module: `cal_time_counter`

## Requirements
- R1: After reset the outputs are seconds 0x00, minutes 0x00, hours 0x00, weekday 0x07, day 0x01, month 0x01, year 0x00 (Saturday 1 January 2000).
- R2: In BCD mode (bin_mode_i = 0) each field carries tens in bits [7:4] and units in bits [3:0]. Seconds and minutes count 00..59, then wrap to 00 and carry into the next field.
- R3: Hours count 00..23. A tick at 23:59:59 gives 00:00:00 and advances both the weekday and the day of month.
- R4: The weekday counts 1..7, with 1 meaning Sunday. It wraps from 7 to 1 at midnight.
- R5: Day of month starts at 1. After the last day it wraps to 1 and advances the month. April, June, September and November have 30 days; January, March, May, July, August, October and December have 31.
- R6: February has 29 days when the two-digit year value is a multiple of 4, and 28 days otherwise.
- R7: Month counts 1..12. Leaving 31 December wraps the month to 1 and advances the year. Year 99 wraps to 00.
- R8: With bin_mode_i = 1 every field is read and produced as a plain binary count with the same ranges. For example, 9 seconds becomes 10 (0x0A).
- R9: While freeze_i is 1, ticks have no effect and no field changes except by a host write.
- R10: With wr_en_i = 1, wr_data_i is stored in the field picked by wr_sel_i and appears on the output after the next rising edge. The wr_sel_i codes are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year. Code 7 changes nothing.
- R11: If a write and a tick arrive in the same cycle, the write is applied and that tick is discarded for all fields.
- R12: Without a tick or a write, all fields hold. Each accepted tick advances the time by exactly one second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance pulse, one cycle wide |
| freeze_i | input | 1 | Hold time: ticks ignored while high |
| bin_mode_i | input | 1 | 1 = binary fields, 0 = packed BCD fields |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Field select for the write |
| wr_data_i | input | 8 | Value written to the selected field |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, 24-hour form |
| wday_o | output | 8 | Weekday, 1 = Sunday |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
Every result of this block is due exactly one rising edge after the cycle that carries the tick or the write. The whole carry chain resolves combinationally, so the outputs right after that edge already show the full rollover. The bench's model applies the inputs it sampled at each rising edge and compares all seven outputs 1 ns later. Directed checks drive stimulus on the falling edge and read the outputs on the following falling edge, one register stage after the capture.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int unsigned FIELD_W    = 8;
    localparam int unsigned NUM_FIELDS = 7;

    // field indices, equal to the write-select codes
    localparam int unsigned I_SEC  = 0;
    localparam int unsigned I_MIN  = 1;
    localparam int unsigned I_HOUR = 2;
    localparam int unsigned I_WDAY = 3;
    localparam int unsigned I_MDAY = 4;
    localparam int unsigned I_MON  = 5;
    localparam int unsigned I_YEAR = 6;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_WDAY = 3'd3,
        SEL_MDAY = 3'd4,
        SEL_MON  = 3'd5,
        SEL_YEAR = 3'd6,
        SEL_NONE = 3'd7
    } cal_sel_e;

    typedef struct packed {
        field_t year;
        field_t mon;
        field_t mday;
        field_t wday;
        field_t hour;
        field_t min;
        field_t sec;
    } cal_time_t;

    // raw field -> plain count, according to the data mode
    function automatic field_t cal_decode(input field_t raw, input logic bin);
        field_t tens_part;
        if (bin) begin
            return raw;
        end
        tens_part = {4'd0, raw[7:4]} * 8'd10;
        return tens_part + {4'd0, raw[3:0]};
    endfunction

    // plain count (below 100) -> raw field, according to the data mode
    function automatic field_t cal_encode(input field_t val, input logic bin);
        field_t tens;
        field_t units;
        tens  = val / 8'd10;
        units = val % 8'd10;
        if (bin) begin
            return val;
        end
        return {tens[3:0], units[3:0]};
    endfunction

endpackage

// File: rtl/cal_field_step.sv
// One counting field: advances by one when enabled, wraps to LOW after
// reaching the limit and reports a carry for the next field.
module cal_field_step
    import cal_pkg::*;
#(
    parameter int unsigned LOW = 0
) (
    input  field_t cur_i,
    input  logic   bin_i,
    input  logic   en_i,
    input  field_t limit_i,
    output field_t nxt_o,
    output logic   carry_o
);

    localparam field_t LOW_VAL = field_t'(LOW);

    field_t dec;
    logic   at_top;

    always_comb begin
        dec     = cal_decode(cur_i, bin_i);
        at_top  = (dec >= limit_i);
        carry_o = en_i && at_top;
        if (!en_i) begin
            nxt_o = cur_i;
        end else if (at_top) begin
            nxt_o = cal_encode(LOW_VAL, bin_i);
        end else begin
            nxt_o = cal_encode(dec + 8'd1, bin_i);
        end
    end

endmodule

// File: rtl/cal_month_len.sv
// Number of days in the current month of the 1950..2049 window.
module cal_month_len
    import cal_pkg::*;
(
    input  field_t mon_i,
    input  field_t year_i,
    input  logic   bin_i,
    output field_t days_o
);

    field_t mon_dec;
    field_t year_dec;
    logic   leap;

    always_comb begin
        mon_dec  = cal_decode(mon_i, bin_i);
        year_dec = cal_decode(year_i, bin_i);
        // 1900 and 2000 are both multiples of four, so the two digits decide
        leap     = (year_dec[1:0] == 2'd0);
        case (mon_dec)
            8'd2:                      days_o = leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   days_o = 8'd30;
            default:                   days_o = 8'd31;
        endcase
    end

endmodule

// File: rtl/cal_time_counter.sv
module cal_time_counter
    import cal_pkg::*;
#(
    parameter field_t RST_SEC  = 8'h00,
    parameter field_t RST_MIN  = 8'h00,
    parameter field_t RST_HOUR = 8'h00,
    parameter field_t RST_WDAY = 8'h07,
    parameter field_t RST_MDAY = 8'h01,
    parameter field_t RST_MON  = 8'h01,
    parameter field_t RST_YEAR = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               freeze_i,
    input  logic               bin_mode_i,
    input  logic               wr_en_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [FIELD_W-1:0] wr_data_i,
    output logic [FIELD_W-1:0] sec_o,
    output logic [FIELD_W-1:0] min_o,
    output logic [FIELD_W-1:0] hour_o,
    output logic [FIELD_W-1:0] wday_o,
    output logic [FIELD_W-1:0] mday_o,
    output logic [FIELD_W-1:0] mon_o,
    output logic [FIELD_W-1:0] year_o
);

    // fields whose count starts at one (weekday, day, month)
    localparam logic [NUM_FIELDS-1:0] ONE_BASED = 7'b0111000;
    localparam field_t LIM_SEC  = 8'd59;
    localparam field_t LIM_MIN  = 8'd59;
    localparam field_t LIM_HOUR = 8'd23;
    localparam field_t LIM_WDAY = 8'd7;
    localparam field_t LIM_MON  = 8'd12;
    localparam field_t LIM_YEAR = 8'd99;

    localparam cal_time_t RST_TIME = '{
        year: RST_YEAR, mon: RST_MON, mday: RST_MDAY, wday: RST_WDAY,
        hour: RST_HOUR, min: RST_MIN, sec: RST_SEC
    };

    cal_time_t state_q;
    cal_time_t state_d;

    field_t cur [NUM_FIELDS];
    field_t nxt [NUM_FIELDS];
    field_t lim [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] en;
    logic [NUM_FIELDS-1:0] cy;
    field_t month_days;
    logic   adv;

    // a write in the same cycle discards the tick
    assign adv = tick_i && !freeze_i && !wr_en_i;

    // carry chain: day and weekday both follow the hour carry
    assign en[I_SEC]  = adv;
    assign en[I_MIN]  = cy[I_SEC];
    assign en[I_HOUR] = cy[I_MIN];
    assign en[I_WDAY] = cy[I_HOUR];
    assign en[I_MDAY] = cy[I_HOUR];
    assign en[I_MON]  = cy[I_MDAY];
    assign en[I_YEAR] = cy[I_MON];

    always_comb begin
        cur[I_SEC]  = state_q.sec;
        cur[I_MIN]  = state_q.min;
        cur[I_HOUR] = state_q.hour;
        cur[I_WDAY] = state_q.wday;
        cur[I_MDAY] = state_q.mday;
        cur[I_MON]  = state_q.mon;
        cur[I_YEAR] = state_q.year;
    end

    always_comb begin
        lim[I_SEC]  = LIM_SEC;
        lim[I_MIN]  = LIM_MIN;
        lim[I_HOUR] = LIM_HOUR;
        lim[I_WDAY] = LIM_WDAY;
        lim[I_MDAY] = month_days;
        lim[I_MON]  = LIM_MON;
        lim[I_YEAR] = LIM_YEAR;
    end

    cal_month_len u_mlen (
        .mon_i  (state_q.mon),
        .year_i (state_q.year),
        .bin_i  (bin_mode_i),
        .days_o (month_days)
    );

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        cal_field_step #(
            .LOW (ONE_BASED[gi] ? 1 : 0)
        ) u_step (
            .cur_i   (cur[gi]),
            .bin_i   (bin_mode_i),
            .en_i    (en[gi]),
            .limit_i (lim[gi]),
            .nxt_o   (nxt[gi]),
            .carry_o (cy[gi])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.sec  = nxt[I_SEC];
        state_d.min  = nxt[I_MIN];
        state_d.hour = nxt[I_HOUR];
        state_d.wday = nxt[I_WDAY];
        state_d.mday = nxt[I_MDAY];
        state_d.mon  = nxt[I_MON];
        state_d.year = nxt[I_YEAR];
        if (wr_en_i) begin
            case (cal_sel_e'(wr_sel_i))
                SEL_SEC:  state_d.sec  = wr_data_i;
                SEL_MIN:  state_d.min  = wr_data_i;
                SEL_HOUR: state_d.hour = wr_data_i;
                SEL_WDAY: state_d.wday = wr_data_i;
                SEL_MDAY: state_d.mday = wr_data_i;
                SEL_MON:  state_d.mon  = wr_data_i;
                SEL_YEAR: state_d.year = wr_data_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_TIME;
        end else begin
            state_q <= state_d;
        end
    end

    assign sec_o  = state_q.sec;
    assign min_o  = state_q.min;
    assign hour_o = state_q.hour;
    assign wday_o = state_q.wday;
    assign mday_o = state_q.mday;
    assign mon_o  = state_q.mon;
    assign year_o = state_q.year;

endmodule

// File: rtl/cal_time_checker.sv
module cal_time_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       freeze_i,
    input logic       bin_mode_i,
    input logic       wr_en_i,
    input logic [2:0] wr_sel_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_o,
    input logic [7:0] min_o,
    input logic [7:0] hour_o,
    input logic [7:0] wday_o,
    input logic [7:0] mday_o,
    input logic [7:0] mon_o,
    input logic [7:0] year_o
);

    logic [55:0] all_fields;
    assign all_fields = {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !wr_en_i) |=> $stable(all_fields)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> $stable(all_fields)); // R12

    AST_BIN_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !wr_en_i && bin_mode_i && sec_o < 8'd59)
        |=> (sec_o == $past(sec_o) + 8'd1)); // R8

    AST_BCD_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !freeze_i && !wr_en_i && !bin_mode_i && sec_o < 8'h59)
        |=> $stable(min_o)); // R2

    AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == $past(wr_data_i))); // R10

    AST_SEL_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 3'd7) |=> $stable(all_fields)); // R10

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && tick_i && !freeze_i && wr_sel_i == 3'd1)
        |=> (sec_o == $past(sec_o) && min_o == $past(wr_data_i))); // R11

endmodule

bind cal_time_counter cal_time_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .freeze_i   (freeze_i),
    .bin_mode_i (bin_mode_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_data_i  (wr_data_i),
    .sec_o      (sec_o),
    .min_o      (min_o),
    .hour_o     (hour_o),
    .wday_o     (wday_o),
    .mday_o     (mday_o),
    .mon_o      (mon_o),
    .year_o     (year_o)
);

// File: tb/cal_time_counter_bench.sv
`timescale 1ns/1ps
module cal_time_counter_bench;

    localparam int HALF = 4; // 125 MHz
    localparam int WATCHDOG_CYC = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       freeze_i = 1'b0;
    logic       bin_mode_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [2:0] wr_sel_i = 3'd0;
    logic [7:0] wr_data_i = 8'd0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";
    logic [7:0] m [7];
    logic finished = 1'b0;

    always #HALF clk = ~clk;

    cal_time_counter u_cal_time_counter (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_i(freeze_i),
        .bin_mode_i(bin_mode_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
        .wday_o(wday_o), .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
    );

    function automatic int mdec(input logic [7:0] r, input logic b);
        if (b) return int'(r);
        return int'(r[7:4]) * 10 + int'(r[3:0]);
    endfunction

    function automatic logic [7:0] menc(input int v, input logic b);
        if (b) return 8'(v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_of(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick(input logic b);
        int v [7];
        for (int i = 0; i < 7; i++) v[i] = mdec(m[i], b);
        v[0]++;
        if (v[0] > 59) begin
            v[0] = 0; v[1]++;
            if (v[1] > 59) begin
                v[1] = 0; v[2]++;
                if (v[2] > 23) begin
                    v[2] = 0;
                    v[3] = (v[3] >= 7) ? 1 : v[3] + 1;
                    v[4]++;
                    if (v[4] > days_of(v[5], v[6])) begin
                        v[4] = 1; v[5]++;
                        if (v[5] > 12) begin
                            v[5] = 1;
                            v[6] = (v[6] >= 99) ? 0 : v[6] + 1;
                        end
                    end
                end
            end
        end
        for (int i = 0; i < 7; i++) m[i] = menc(v[i], b);
    endtask

    // reference model, compared on every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h00; m[3] = 8'h07;
            m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00;
        end else begin
            if (wr_en_i) begin
                if (wr_sel_i != 3'd7) m[wr_sel_i] = wr_data_i;
            end else if (tick_i && !freeze_i) begin
                model_tick(bin_mode_i);
            end
            #1;
            checks++;
            if ({year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o} !=
                {m[6], m[5], m[4], m[3], m[2], m[1], m[0]}) begin
                failures++;
                $display("FAIL %s model: actual=%h expected=%h", cur_req,
                    {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o},
                    {m[6], m[5], m[4], m[3], m[2], m[1], m[0]});
            end
        end
    end

    task automatic expect_time(input string req, input logic [7:0] s, mi, h,
                               w, d, mo, y);
        checks++;
        if ({year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o} !=
            {y, mo, d, w, h, mi, s}) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req,
                {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o},
                {y, mo, d, w, h, mi, s});
        end
    endtask

    task automatic write_field(input logic [2:0] sel, input logic [7:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, w, d, mo, y);
        write_field(3'd0, s); write_field(3'd1, mi); write_field(3'd2, h);
        write_field(3'd3, w); write_field(3'd4, d); write_field(3'd5, mo);
        write_field(3'd6, y);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
        end
        tick_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        expect_time("R1 reset", 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00);

        cur_req = "R12";
        ticks(1);
        expect_time("R12 one tick", 8'h01, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00);
        repeat (3) @(negedge clk);
        expect_time("R12 idle hold", 8'h01, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00);

        cur_req = "R2";
        set_time(8'h58, 8'h00, 8'h00, 8'h02, 8'h10, 8'h03, 8'h24);
        ticks(2);
        expect_time("R2 sec wrap", 8'h00, 8'h01, 8'h00, 8'h02, 8'h10, 8'h03, 8'h24);
        set_time(8'h59, 8'h09, 8'h05, 8'h02, 8'h10, 8'h03, 8'h24);
        ticks(1);
        expect_time("R2 bcd nibble carry", 8'h00, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h24);

        cur_req = "R3";
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h24);
        ticks(1);
        expect_time("R3 R4 midnight", 8'h00, 8'h00, 8'h00, 8'h01, 8'h16, 8'h06, 8'h24);

        cur_req = "R5";
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h24);
        ticks(1);
        expect_time("R5 april end", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h05, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h01, 8'h24);
        ticks(1);
        expect_time("R5 jan 31st", 8'h00, 8'h00, 8'h00, 8'h06, 8'h31, 8'h01, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h07, 8'h24);
        ticks(1);
        expect_time("R5 july end", 8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h08, 8'h24);

        cur_req = "R6";
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        ticks(1);
        expect_time("R6 leap feb 29", 8'h00, 8'h00, 8'h00, 8'h04, 8'h29, 8'h02, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        ticks(1);
        expect_time("R6 leap mar 1", 8'h00, 8'h00, 8'h00, 8'h05, 8'h01, 8'h03, 8'h24);
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        ticks(1);
        expect_time("R6 common year", 8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00);
        ticks(1);
        expect_time("R6 year 2000", 8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h50);
        ticks(1);
        expect_time("R6 year 1950", 8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h50);

        cur_req = "R7";
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        ticks(1);
        expect_time("R7 year 99 wrap", 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h00);
        set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h49);
        ticks(1);
        expect_time("R7 year 49 to 50", 8'h00, 8'h00, 8'h00, 8'h07, 8'h01, 8'h01, 8'h50);

        cur_req = "R9";
        set_time(8'h10, 8'h20, 8'h08, 8'h02, 8'h05, 8'h09, 8'h30);
        freeze_i = 1'b1;
        ticks(5);
        expect_time("R9 frozen", 8'h10, 8'h20, 8'h08, 8'h02, 8'h05, 8'h09, 8'h30);
        write_field(3'd0, 8'h33);
        expect_time("R9 write while frozen", 8'h33, 8'h20, 8'h08, 8'h02, 8'h05, 8'h09, 8'h30);
        freeze_i = 1'b0;

        cur_req = "R10";
        write_field(3'd7, 8'h44);
        expect_time("R10 select 7 ignored", 8'h33, 8'h20, 8'h08, 8'h02, 8'h05, 8'h09, 8'h30);
        write_field(3'd2, 8'h17);
        expect_time("R10 hour write", 8'h33, 8'h20, 8'h17, 8'h02, 8'h05, 8'h09, 8'h30);

        cur_req = "R11";
        write_field(3'd0, 8'h59);
        tick_i = 1'b1; wr_en_i = 1'b1; wr_sel_i = 3'd1; wr_data_i = 8'h42;
        @(negedge clk);
        tick_i = 1'b0; wr_en_i = 1'b0;
        expect_time("R11 write wins", 8'h59, 8'h42, 8'h17, 8'h02, 8'h05, 8'h09, 8'h30);

        cur_req = "R8";
        bin_mode_i = 1'b1;
        set_time(8'd59, 8'd59, 8'd23, 8'd7, 8'd31, 8'd12, 8'd99);
        ticks(1);
        expect_time("R8 binary year wrap", 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
        set_time(8'd9, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
        ticks(1);
        expect_time("R8 binary count", 8'd10, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd0);
        set_time(8'd59, 8'd59, 8'd23, 8'd3, 8'd28, 8'd2, 8'd48);
        ticks(1);
        expect_time("R8 R6 binary leap", 8'd0, 8'd0, 8'd0, 8'd4, 8'd29, 8'd2, 8'd48);

        cur_req = "R12 long run";
        bin_mode_i = 1'b0;
        set_time(8'h00, 8'h00, 8'h23, 8'h05, 8'h28, 8'h02, 8'h24);
        ticks(90000);
        repeat (2) @(negedge clk);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R12 watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule